// File: doc/BRIEF.md
# Clipped 2D Block Transfer Engine

The engine moves a rectangular tile of 8-bit pixels between a large image held in external memory and a contiguous tile buffer on chip. In load direction it gathers the tile row by row from the strided image into consecutive buffer words. In store direction it scatters a processed tile from the buffer back into the image. Software programs the image origin address, the row pitch, the image width and height, a signed tile origin, the tile width and height and the buffer base, then pulses `start`.

The tile may hang over any edge of the image or miss it completely. Once per job the engine derives the column and row intervals of the tile that overlap the image. It then reports whether the tile is fully inside, partly inside or fully outside. External memory is touched only for pixels inside the image. In load direction every other buffer position receives zero. In store direction the outside pixels are skipped, and their buffer words are never read.

Both memory ports are single-word request ports that accept a request in every cycle. A read request shown in one cycle returns its data in the following cycle. A job handles one pixel at a time. A fetched pixel costs four cycles, and a pixel that is zero-filled or skipped costs two.

Top module: `dma2d_engine`

## Requirements
- R1: In load direction (`dir`=0), buffer word `buf_base + cy*blk_w + cx` receives the image byte at `img_base + (org_y+cy)*img_pitch + (org_x+cx)` for every tile pixel whose image coordinate satisfies 0 ≤ x < `img_w` and 0 ≤ y < `img_h`.
- R2: A tile with no pixel inside the image issues no external read, writes zero to all `blk_w*blk_h` buffer words, and reports `blk_class` = 2.
- R3: A tile that overlaps the image partly reads only addresses inside the image, issues exactly as many reads as overlapping pixels, writes zero to every other buffer word, and reports `blk_class` = 1.
- R4: A tile fully inside the image reads every one of its pixels and reports `blk_class` = 0.
- R5: In store direction (`dir`=1), each in-image pixel's byte at the R1 address receives buffer word `buf_base + cy*blk_w + cx`. No external write falls outside the image, including the pitch gap beyond `img_w`. Buffer reads and external writes both equal the overlap count.
- R6: `org_x` and `org_y` are two's complement, so a tile may start left of or above the image.
- R7: `done` is high for exactly one cycle, in the cycle after the last pixel's write or skip, and `busy` is already low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored: the running job completes with its original settings and no second job follows.
- R9: A tile with zero width or zero height completes with one `done` pulse, no memory access on either port, and `blk_class` = 2.
- R10: After reset, `busy`, `done`, `ext_req` and `loc_en` are low and `blk_class` is 0.
- R11: The engine never drives requests on both ports in one cycle, and it drives no request while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job with the settings presented in this cycle |
| dir | input | 1 | 0: image to buffer, 1: buffer to image |
| img_base | input | ADDR_W | External address of image pixel (0,0) |
| img_pitch | input | ADDR_W | Address distance between image rows |
| img_w | input | DIM_W | Image width in pixels |
| img_h | input | DIM_W | Image height in rows |
| org_x | input | DIM_W+1 | Signed tile origin column |
| org_y | input | DIM_W+1 | Signed tile origin row |
| blk_w | input | BLK_DW | Tile width |
| blk_h | input | BLK_DW | Tile height |
| buf_base | input | BUF_AW | Buffer address of tile pixel (0,0) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| blk_class | output | 2 | 0 inside, 1 partial, 2 outside |
| ext_req | output | 1 | External memory request |
| ext_we | output | 1 | External request is a write |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | PIX_W | External write data |
| ext_rdata | input | PIX_W | External read data, one cycle after the request |
| loc_en | output | 1 | Buffer request |
| loc_we | output | 1 | Buffer request is a write |
| loc_addr | output | BUF_AW | Buffer address |
| loc_wdata | output | PIX_W | Buffer write data |
| loc_rdata | input | PIX_W | Buffer read data, one cycle after the request |

## Verification
The bench builds the engine with a 12-bit external address, 8-bit image dimensions, 5-bit tile dimensions and an 8-bit buffer address. These values fit a whole 4 KB external model and a 256-word buffer model in the bench. The image is 32 by 20 with a pitch of 40. An 8 by 6 tile, larger than a 32-byte line, can then reach the left, top, right and bottom edges and the unused pitch gap. It can also sit fully inside, and negative origins are exercised. A short job finishes in under two hundred cycles, so every class and both directions fit in one run.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    CLS_INSIDE  = 2'd0,
    CLS_PARTIAL = 2'd1,
    CLS_OUTSIDE = 2'd2
  } blk_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLIP,
    ST_PIX,
    ST_RD,
    ST_DAT,
    ST_ADV
  } eng_state_e;

  localparam logic DIR_LOAD  = 1'b0;
  localparam logic DIR_STORE = 1'b1;

endpackage

// File: rtl/dma2d_span.sv
// One-axis overlap: tile-local interval [lo, hi) that falls inside [0, lim).
module dma2d_span #(
  parameter int DIM_W = 12,
  parameter int LEN_W = 7
) (
  input  logic signed [DIM_W:0]   org,
  input  logic        [DIM_W-1:0] lim,
  input  logic        [LEN_W-1:0] len,
  output logic        [LEN_W-1:0] lo,
  output logic        [LEN_W-1:0] hi
);
  localparam int SW = ((DIM_W > LEN_W) ? DIM_W : LEN_W) + 3;

  logic signed [SW-1:0] org_s, lim_s, len_s, lo_raw, hi_raw;

  assign org_s  = SW'(org);
  assign lim_s  = SW'(lim);
  assign len_s  = SW'(len);
  assign lo_raw = -org_s;
  assign hi_raw = lim_s - org_s;

  always_comb begin
    if (lo_raw[SW-1])        lo = '0;
    else if (lo_raw > len_s) lo = len;
    else                     lo = lo_raw[LEN_W-1:0];

    if (hi_raw[SW-1])        hi = '0;
    else if (hi_raw > len_s) hi = len;
    else                     hi = hi_raw[LEN_W-1:0];
  end
endmodule

// File: rtl/dma2d_walker.sv
// Tile scan counters plus source and destination address generation.
module dma2d_walker #(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12,
  parameter int BLK_DW = 7,
  parameter int BUF_AW = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init,
  input  logic                     step,
  input  logic        [ADDR_W-1:0] base,
  input  logic        [ADDR_W-1:0] pitch,
  input  logic signed [DIM_W:0]    ox,
  input  logic signed [DIM_W:0]    oy,
  input  logic        [BLK_DW-1:0] bw,
  input  logic        [BLK_DW-1:0] bh,
  input  logic        [BUF_AW-1:0] buf_base,
  input  logic        [BLK_DW-1:0] lo_x,
  input  logic        [BLK_DW-1:0] hi_x,
  input  logic        [BLK_DW-1:0] lo_y,
  input  logic        [BLK_DW-1:0] hi_y,
  output logic        [ADDR_W-1:0] src_addr,
  output logic        [BUF_AW-1:0] dst_addr,
  output logic                     pix_valid,
  output logic                     last
);
  localparam int OW = ADDR_W + DIM_W + 2;

  logic signed [OW-1:0] base_s, pitch_s, ox_s, oy_s, org_sum;
  logic [BLK_DW-1:0] cx_q, cy_q;
  logic [ADDR_W-1:0] row_q;
  logic [BUF_AW-1:0] dst_q;
  logic              row_end;

  // Address of tile pixel (0,0), modulo the address space; used only once per job.
  assign base_s  = OW'(base);
  assign pitch_s = OW'(pitch);
  assign ox_s    = OW'(ox);
  assign oy_s    = OW'(oy);
  assign org_sum = base_s + oy_s * pitch_s + ox_s;

  assign row_end = (cx_q == bw - BLK_DW'(1));
  assign last    = row_end && (cy_q == bh - BLK_DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cx_q  <= '0;
      cy_q  <= '0;
      row_q <= '0;
      dst_q <= '0;
    end else if (init) begin
      cx_q  <= '0;
      cy_q  <= '0;
      row_q <= org_sum[ADDR_W-1:0];
      dst_q <= buf_base;
    end else if (step) begin
      dst_q <= dst_q + BUF_AW'(1);
      if (row_end) begin
        cx_q  <= '0;
        cy_q  <= cy_q + BLK_DW'(1);
        row_q <= row_q + pitch;
      end else begin
        cx_q <= cx_q + BLK_DW'(1);
      end
    end
  end

  assign pix_valid = (cx_q >= lo_x) && (cx_q < hi_x) &&
                     (cy_q >= lo_y) && (cy_q < hi_y);
  assign src_addr  = row_q + ADDR_W'(cx_q);
  assign dst_addr  = dst_q;
endmodule

// File: rtl/dma2d_ctrl.sv
// Job sequencer with registered memory-port outputs.
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUF_AW = 12,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic              empty,
  input  logic              pix_valid,
  input  logic              last,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [BUF_AW-1:0] dst_addr,
  input  logic [PIX_W-1:0]  ext_rdata,
  input  logic [PIX_W-1:0]  loc_rdata,
  output logic              accept,
  output logic              w_init,
  output logic              w_step,
  output logic              cls_load,
  output logic              busy,
  output logic              done,
  output logic              ext_req,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [PIX_W-1:0]  ext_wdata,
  output logic              loc_en,
  output logic              loc_we,
  output logic [BUF_AW-1:0] loc_addr,
  output logic [PIX_W-1:0]  loc_wdata
);
  eng_state_e state_q;

  assign accept   = (state_q == ST_IDLE) && start;
  assign w_init   = (state_q == ST_CLIP);
  assign cls_load = (state_q == ST_CLIP);
  assign w_step   = (state_q == ST_ADV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      loc_en    <= 1'b0;
      loc_we    <= 1'b0;
      loc_addr  <= '0;
      loc_wdata <= '0;
    end else begin
      done    <= 1'b0;
      ext_req <= 1'b0;
      ext_we  <= 1'b0;
      loc_en  <= 1'b0;
      loc_we  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            state_q <= ST_CLIP;
          end
        end
        ST_CLIP: begin
          if (empty) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PIX;
          end
        end
        ST_PIX: begin
          if (pix_valid) begin
            if (dir == DIR_LOAD) begin
              ext_req  <= 1'b1;
              ext_addr <= src_addr;
            end else begin
              loc_en   <= 1'b1;
              loc_addr <= dst_addr;
            end
            state_q <= ST_RD;
          end else begin
            if (dir == DIR_LOAD) begin
              loc_en    <= 1'b1;
              loc_we    <= 1'b1;
              loc_addr  <= dst_addr;
              loc_wdata <= '0;
            end
            state_q <= ST_ADV;
          end
        end
        ST_RD: begin
          state_q <= ST_DAT;
        end
        ST_DAT: begin
          if (dir == DIR_LOAD) begin
            loc_en    <= 1'b1;
            loc_we    <= 1'b1;
            loc_addr  <= dst_addr;
            loc_wdata <= ext_rdata;
          end else begin
            ext_req   <= 1'b1;
            ext_we    <= 1'b1;
            ext_addr  <= src_addr;
            ext_wdata <= loc_rdata;
          end
          state_q <= ST_ADV;
        end
        ST_ADV: begin
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PIX;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12,
  parameter int BLK_DW = 7,
  parameter int BUF_AW = 12,
  parameter int PIX_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     dir,
  input  logic        [ADDR_W-1:0] img_base,
  input  logic        [ADDR_W-1:0] img_pitch,
  input  logic        [DIM_W-1:0]  img_w,
  input  logic        [DIM_W-1:0]  img_h,
  input  logic signed [DIM_W:0]    org_x,
  input  logic signed [DIM_W:0]    org_y,
  input  logic        [BLK_DW-1:0] blk_w,
  input  logic        [BLK_DW-1:0] blk_h,
  input  logic        [BUF_AW-1:0] buf_base,
  output logic                     busy,
  output logic                     done,
  output logic        [1:0]        blk_class,
  output logic                     ext_req,
  output logic                     ext_we,
  output logic        [ADDR_W-1:0] ext_addr,
  output logic        [PIX_W-1:0]  ext_wdata,
  input  logic        [PIX_W-1:0]  ext_rdata,
  output logic                     loc_en,
  output logic                     loc_we,
  output logic        [BUF_AW-1:0] loc_addr,
  output logic        [PIX_W-1:0]  loc_wdata,
  input  logic        [PIX_W-1:0]  loc_rdata
);
  // Job settings captured at start.
  logic                     dir_q;
  logic        [ADDR_W-1:0] base_q, pitch_q;
  logic        [DIM_W-1:0]  w_q, h_q;
  logic signed [DIM_W:0]    ox_q, oy_q;
  logic        [BLK_DW-1:0] bw_q, bh_q;
  logic        [BUF_AW-1:0] bb_q;

  logic accept, w_init, w_step, cls_load;
  logic [BLK_DW-1:0] lo_x, hi_x, lo_y, hi_y;
  logic [ADDR_W-1:0] src_addr;
  logic [BUF_AW-1:0] dst_addr;
  logic pix_valid, last, empty;
  blk_class_e cls_next, cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_LOAD;
      base_q  <= '0;
      pitch_q <= '0;
      w_q     <= '0;
      h_q     <= '0;
      ox_q    <= '0;
      oy_q    <= '0;
      bw_q    <= '0;
      bh_q    <= '0;
      bb_q    <= '0;
    end else if (accept) begin
      dir_q   <= dir;
      base_q  <= img_base;
      pitch_q <= img_pitch;
      w_q     <= img_w;
      h_q     <= img_h;
      ox_q    <= org_x;
      oy_q    <= org_y;
      bw_q    <= blk_w;
      bh_q    <= blk_h;
      bb_q    <= buf_base;
    end
  end

  dma2d_span #(.DIM_W(DIM_W), .LEN_W(BLK_DW)) u_span_x (
    .org(ox_q), .lim(w_q), .len(bw_q), .lo(lo_x), .hi(hi_x)
  );

  dma2d_span #(.DIM_W(DIM_W), .LEN_W(BLK_DW)) u_span_y (
    .org(oy_q), .lim(h_q), .len(bh_q), .lo(lo_y), .hi(hi_y)
  );

  assign empty = (bw_q == '0) || (bh_q == '0);

  always_comb begin
    if ((lo_x >= hi_x) || (lo_y >= hi_y))
      cls_next = CLS_OUTSIDE;
    else if ((lo_x == '0) && (hi_x == bw_q) && (lo_y == '0) && (hi_y == bh_q))
      cls_next = CLS_INSIDE;
    else
      cls_next = CLS_PARTIAL;
  end

  always_ff @(posedge clk) begin
    if (rst)           cls_q <= CLS_INSIDE;
    else if (cls_load) cls_q <= cls_next;
  end

  assign blk_class = cls_q;

  dma2d_walker #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .BLK_DW(BLK_DW), .BUF_AW(BUF_AW)
  ) u_walk (
    .clk(clk), .rst(rst), .init(w_init), .step(w_step),
    .base(base_q), .pitch(pitch_q), .ox(ox_q), .oy(oy_q),
    .bw(bw_q), .bh(bh_q), .buf_base(bb_q),
    .lo_x(lo_x), .hi_x(hi_x), .lo_y(lo_y), .hi_y(hi_y),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .pix_valid(pix_valid), .last(last)
  );

  dma2d_ctrl #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .dir(dir_q), .empty(empty),
    .pix_valid(pix_valid), .last(last),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .ext_rdata(ext_rdata), .loc_rdata(loc_rdata),
    .accept(accept), .w_init(w_init), .w_step(w_step), .cls_load(cls_load),
    .busy(busy), .done(done),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata)
  );
endmodule

// File: rtl/dma2d_engine_chk.sv
module dma2d_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] blk_class,
  input logic       ext_req,
  input logic       ext_we,
  input logic       loc_en
);
  // R7: completion pulse lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy has dropped when done is shown
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: never both memory ports in one cycle
  a_r11_one_port: assert property (@(posedge clk) disable iff (rst)
    !(ext_req && loc_en));

  // R11: no traffic outside a job
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ext_req && !loc_en));

  // R2: a tile classed outside never reads external memory
  a_r2_outside_no_read: assert property (@(posedge clk) disable iff (rst)
    (busy && blk_class == 2'd2) |-> !(ext_req && !ext_we));

  // R8: a job begins only from a start seen while idle
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind dma2d_engine dma2d_engine_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .blk_class(blk_class), .ext_req(ext_req), .ext_we(ext_we), .loc_en(loc_en)
);

// File: tb/sim_dma2d_engine.sv
module sim_dma2d_engine;
  localparam int AW = 12, DW = 8, BW = 5, BAW = 8;
  localparam int IMG_BASE = 256, IMG_PITCH = 40, IMG_W = 32, IMG_H = 20;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dir = 1'b0;
  logic [AW-1:0] img_base = AW'(IMG_BASE), img_pitch = AW'(IMG_PITCH);
  logic [DW-1:0] img_w = DW'(IMG_W), img_h = DW'(IMG_H);
  logic signed [DW:0] org_x = '0, org_y = '0;
  logic [BW-1:0] blk_w = '0, blk_h = '0;
  logic [BAW-1:0] buf_base = '0;
  logic busy, done, ext_req, ext_we, loc_en, loc_we;
  logic [1:0] blk_class;
  logic [AW-1:0] ext_addr;
  logic [BAW-1:0] loc_addr;
  logic [7:0] ext_wdata, loc_wdata, ext_rdata, loc_rdata;

  logic [7:0] ext_mem [0:4095];
  logic [7:0] loc_mem [0:255];

  int checks = 0, fails = 0;
  int ext_rd = 0, ext_wr = 0, ext_bad = 0, loc_acc = 0, loc_wr = 0, done_cnt = 0;

  always #4 clk = ~clk;

  dma2d_engine #(.ADDR_W(AW), .DIM_W(DW), .BLK_DW(BW), .BUF_AW(BAW), .PIX_W(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .dir(dir),
    .img_base(img_base), .img_pitch(img_pitch), .img_w(img_w), .img_h(img_h),
    .org_x(org_x), .org_y(org_y), .blk_w(blk_w), .blk_h(blk_h), .buf_base(buf_base),
    .busy(busy), .done(done), .blk_class(blk_class),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata),
    .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  // Memory models: one-cycle read latency.
  always @(posedge clk) begin
    if (ext_req) begin
      if (ext_we) ext_mem[ext_addr] <= ext_wdata;
      else        ext_rdata <= ext_mem[ext_addr];
    end
    if (loc_en) begin
      if (loc_we) loc_mem[loc_addr] <= loc_wdata;
      else        loc_rdata <= loc_mem[loc_addr];
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'(a * 5 + 1) | 8'h01;
  endfunction

  function automatic bit in_img(int a);
    int off;
    off = a - IMG_BASE;
    if (off < 0) return 1'b0;
    return ((off / IMG_PITCH) < IMG_H) && ((off % IMG_PITCH) < IMG_W);
  endfunction

  function automatic bit pix_in(int gx, int gy);
    return (gx >= 0) && (gx < IMG_W) && (gy >= 0) && (gy < IMG_H);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (ext_req) begin
        if (ext_we) ext_wr++; else ext_rd++;
        if (!in_img(int'(ext_addr))) ext_bad++;
      end
      if (loc_en) begin
        loc_acc++;
        if (loc_we) loc_wr++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic init_ext();
    for (int a = 0; a < 4096; a++) ext_mem[a] = pat(a);
  endtask

  task automatic fill_loc(input logic [7:0] v);
    for (int a = 0; a < 256; a++) loc_mem[a] = v;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R7 done reached", int'(done), 1);
    check(!busy, "R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R7 done lasts one cycle", int'(done), 0);
  endtask

  task automatic launch(input bit d, input int ox, input int oy, input int bw, input int bh,
                        input int bb);
    @(negedge clk);
    dir = d; org_x = (DW+1)'(ox); org_y = (DW+1)'(oy);
    blk_w = BW'(bw); blk_h = BW'(bh); buf_base = BAW'(bb);
    ext_rd = 0; ext_wr = 0; ext_bad = 0; loc_acc = 0; loc_wr = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Load and compare every buffer word with the clipped image.
  task automatic load_case(input string req, input int ox, input int oy, input int bw,
                           input int bh, input int bb, input int exp_cls);
    int mism, ov, first_a, first_e;
    fill_loc(8'hEE);
    launch(1'b0, ox, oy, bw, bh, bb);
    wait_done();
    mism = 0; ov = 0; first_a = 0; first_e = 0;
    for (int cy = 0; cy < bh; cy++) begin
      for (int cx = 0; cx < bw; cx++) begin
        int gx, gy, e, a;
        gx = ox + cx; gy = oy + cy;
        e = pix_in(gx, gy) ? int'(pat(IMG_BASE + gy * IMG_PITCH + gx)) : 0;
        if (pix_in(gx, gy)) ov++;
        a = int'(loc_mem[bb + cy * bw + cx]);
        if (a != e) begin
          if (mism == 0) begin first_a = a; first_e = e; end
          mism++;
        end
      end
    end
    check(mism == 0, {req, " R1 buffer contents"}, first_a, first_e);
    check(ext_rd == ov, {req, " external read count"}, ext_rd, ov);
    check(ext_bad == 0, {req, " reads stay in image"}, ext_bad, 0);
    check(ext_wr == 0, {req, " no external write on load"}, ext_wr, 0);
    check(loc_wr == bw * bh, {req, " every buffer word written"}, loc_wr, bw * bh);
    check(int'(blk_class) == exp_cls, {req, " class"}, int'(blk_class), exp_cls);
  endtask

  task automatic test_reset();
    check(!busy && !done, "R10 busy/done after reset", int'({busy, done}), 0);
    check(!ext_req && !loc_en, "R10 no request after reset", int'({ext_req, loc_en}), 0);
    check(blk_class == 2'd0, "R10 class after reset", int'(blk_class), 0);
  endtask

  task automatic test_inside();
    init_ext();
    load_case("R4", 3, 2, 8, 6, 0, 0);
  endtask

  task automatic test_partial_negative();
    init_ext();
    load_case("R3 R6", -3, -2, 8, 6, 16, 1);
  endtask

  task automatic test_partial_far_edge();
    init_ext();
    load_case("R3", 28, 17, 8, 6, 100, 1);
  endtask

  task automatic test_outside();
    init_ext();
    load_case("R2 R6", -20, 3, 8, 6, 0, 2);
    check(ext_rd == 0, "R2 no external read", ext_rd, 0);
  endtask

  // Store a numbered tile, then compare the whole image area including the pitch gap.
  task automatic store_case(input int ox, input int oy);
    int mism, ov, first_a, first_e;
    init_ext();
    for (int i = 0; i < 256; i++) loc_mem[i] = 8'(8'h80 + i);
    launch(1'b1, ox, oy, 8, 6, 0);
    wait_done();
    mism = 0; ov = 0; first_a = 0; first_e = 0;
    for (int a = IMG_BASE; a < IMG_BASE + IMG_H * IMG_PITCH; a++) begin
      int gx, gy, cx, cy, e;
      gy = (a - IMG_BASE) / IMG_PITCH;
      gx = (a - IMG_BASE) % IMG_PITCH;
      cx = gx - ox; cy = gy - oy;
      if (gx < IMG_W && cx >= 0 && cx < 8 && cy >= 0 && cy < 6) begin
        e = int'(8'(8'h80 + cy * 8 + cx));
        ov++;
      end else begin
        e = int'(pat(a));
      end
      if (int'(ext_mem[a]) != e) begin
        if (mism == 0) begin first_a = int'(ext_mem[a]); first_e = e; end
        mism++;
      end
    end
    check(mism == 0, "R5 image after store", first_a, first_e);
    check(ext_wr == ov, "R5 external write count", ext_wr, ov);
    check(ext_bad == 0, "R5 writes stay in image", ext_bad, 0);
    check(loc_acc == ov, "R5 buffer reads equal overlap", loc_acc, ov);
    check(ext_rd == 0, "R5 no external read on store", ext_rd, 0);
  endtask

  task automatic test_store();
    store_case(-2, 1);
    check(blk_class == 2'd1, "R5 R6 class of store tile", int'(blk_class), 1);
    store_case(28, 17);
  endtask

  task automatic test_start_while_busy();
    int mism;
    init_ext();
    fill_loc(8'hEE);
    launch(1'b0, 3, 2, 8, 6, 0);
    repeat (5) @(negedge clk);
    check(busy, "R8 job running", int'(busy), 1);
    dir = 1'b1; org_x = -(DW+1)'(50); blk_w = BW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    mism = 0;
    for (int cy = 0; cy < 6; cy++)
      for (int cx = 0; cx < 8; cx++)
        if (loc_mem[cy * 8 + cx] != pat(IMG_BASE + (2 + cy) * IMG_PITCH + 3 + cx)) mism++;
    check(mism == 0, "R8 original job result kept", mism, 0);
    check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    check(!busy, "R8 no second job", int'(busy), 0);
    check(ext_wr == 0, "R8 no store started", ext_wr, 0);
  endtask

  task automatic test_zero_size();
    fill_loc(8'hEE);
    launch(1'b0, 3, 2, 0, 4, 0);
    wait_done();
    check(ext_rd + ext_wr == 0, "R9 no external access", ext_rd + ext_wr, 0);
    check(loc_acc == 0, "R9 no buffer access", loc_acc, 0);
    check(int'(blk_class) == 2, "R9 class", int'(blk_class), 2);
    check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    init_ext();
    fill_loc(8'h00);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_inside();
    test_partial_negative();
    test_partial_far_edge();
    test_outside();
    test_store();
    test_start_while_busy();
    test_zero_size();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule